// File: doc/BRIEF.md
# Serial Control Word Loader

This block is the programming front end of a frequency synthesizer's control logic. A host sends 24-bit words over three wires: a serial clock, a serial data line and a latch-enable strobe. The data line is sampled on each rising edge of the serial clock, most significant bit first, into a 24-bit shift register. A rising edge on the strobe then copies the upper 22 bits of the word into one of four control latches.

The two lowest bits of each word pick the latch. Code 00 selects the reference-divider latch, 01 the feedback-divider latch, 10 the function latch and 11 the initialization latch. A write to the initialization latch also places the same payload in the function latch. The block decodes fixed fields from the latches for the neighbouring logic: the reference divide ratio, the A and B divide values, the lock-detect precision flag, the antibacklash width code and the output multiplexer select.

An active-high asynchronous reset clears the shift register and all four latches.

Top module: `ctrl_word_loader`

## Requirements
- R1: A high level on `rst` clears all four latches and all decoded fields to zero without waiting for any clock edge.
- R2: Each rising edge of `sclk` shifts `sdata` into the word, most significant bit first. Only the last 24 bits shifted in before a strobe matter, and earlier bits are pushed out.
- R3: On a rising edge of `le`, a word whose bits [1:0] are 00 writes its bits [23:2] into the reference-divider latch.
- R4: On a rising edge of `le`, code 01 writes bits [23:2] into the feedback-divider latch.
- R5: On a rising edge of `le`, code 10 writes bits [23:2] into the function latch.
- R6: On a rising edge of `le`, code 11 writes bits [23:2] into both the initialization latch and the function latch.
- R7: On each strobe, every latch that the code does not select keeps its previous value.
- R8: The reference-divider latch decodes to the reference divide ratio at word bits [15:2], the antibacklash width code at bits [17:16] and the lock-detect precision flag at bit 20.
- R9: The feedback-divider latch decodes to the A value at word bits [7:2] and the B value at bits [20:8].
- R10: The function latch decodes to the 3-bit output multiplexer select at word bits [6:4].
- R11: Serial clock edges with no strobe change no latch and no decoded field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. Data is sampled on its rising edge. |
| sdata | input | 1 | Serial data, MSB first |
| le | input | 1 | Latch-enable strobe. Its rising edge loads a latch. |
| rst | input | 1 | Asynchronous active-high reset |
| lat_ref | output | 22 | Reference-divider latch, word bits [23:2] |
| lat_div | output | 22 | Feedback-divider latch, word bits [23:2] |
| lat_func | output | 22 | Function latch, word bits [23:2] |
| lat_init | output | 22 | Initialization latch, word bits [23:2] |
| ref_div | output | 14 | Reference divide ratio |
| a_val | output | 6 | A divide value |
| b_val | output | 13 | B divide value |
| lock_prec | output | 1 | Lock-detect precision flag |
| abw_sel | output | 2 | Antibacklash width code |
| mux_sel | output | 3 | Output multiplexer select |

## Verification
A shift register with a bit in the wrong place shows up on the first strobe after it, as a payload shifted or corrupted in the selected latch. A bad code decode shows up on that same strobe: the wrong latch changes, or a latch that should stay fixed is overwritten, so the bench compares all four latches after every load. Field decoding errors show up at once on the decoded outputs. Sweeping A and the multiplexer select through every value, and several spread values for B and the reference ratio, exposes a swapped or off-by-one slice.

// File: rtl/cwl_pkg.sv
package cwl_pkg;

    localparam int WORD_W  = 24;
    localparam int CTRL_W  = 2;
    localparam int N_LATCH = 4;
    localparam int PAY_LO  = CTRL_W;
    localparam int PAY_HI  = WORD_W - 1;
    localparam int PAY_W   = PAY_HI - PAY_LO + 1;

    // field positions, expressed in word bit numbers
    localparam int RDIV_LO = 2;
    localparam int RDIV_W  = 14;
    localparam int ABW_LO  = 16;
    localparam int ABW_W   = 2;
    localparam int PREC_AT = 20;
    localparam int AVAL_LO = 2;
    localparam int AVAL_W  = 6;
    localparam int BVAL_LO = 8;
    localparam int BVAL_W  = 13;
    localparam int MUX_LO  = 4;
    localparam int MUX_W   = 3;

    typedef enum logic [CTRL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_DIV  = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } latch_sel_e;

    typedef logic [PAY_HI:PAY_LO] payload_t;

    typedef struct packed {
        logic [RDIV_W-1:0] rdiv;
        logic [ABW_W-1:0]  abw;
        logic              prec;
        logic [AVAL_W-1:0] aval;
        logic [BVAL_W-1:0] bval;
        logic [MUX_W-1:0]  mux;
    } fields_t;

    function automatic latch_sel_e ctrl_of(input logic [WORD_W-1:0] w);
        return latch_sel_e'(w[CTRL_W-1:0]);
    endfunction

    // a latch is written when addressed directly; the function latch also
    // follows writes to the initialization latch
    function automatic logic latch_hit(input int idx, input latch_sel_e s);
        return (int'(s) == idx) || ((idx == int'(SEL_FUNC)) && (s == SEL_INIT));
    endfunction

endpackage

// File: rtl/cwl_shift.sv
module cwl_shift
    import cwl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         sclk,
    input  logic         rst,
    input  logic         sdata,
    output logic [W-1:0] word
);

    always_ff @(posedge sclk or posedge rst) begin
        if (rst) begin
            word <= '0;
        end else begin
            word <= {word[W-2:0], sdata};
        end
    end

endmodule

// File: rtl/cwl_bank.sv
module cwl_bank
    import cwl_pkg::*;
(
    input  logic                  le,
    input  logic                  rst,
    input  logic [WORD_W-1:0]     word,
    output logic [N_LATCH-1:0][PAY_W-1:0] lat
);

    latch_sel_e sel;
    assign sel = ctrl_of(word);

    for (genvar i = 0; i < N_LATCH; i++) begin : g_lat
        payload_t q;
        always_ff @(posedge le or posedge rst) begin
            if (rst) begin
                q <= '0;
            end else if (latch_hit(i, sel)) begin
                q <= word[PAY_HI:PAY_LO];
            end
        end
        assign lat[i] = q;
    end

endmodule

// File: rtl/cwl_decode.sv
module cwl_decode
    import cwl_pkg::*;
(
    input  payload_t ref_q,
    input  payload_t div_q,
    input  payload_t func_q,
    output fields_t  fld
);

    always_comb begin
        fld.rdiv = ref_q[RDIV_LO +: RDIV_W];
        fld.abw  = ref_q[ABW_LO +: ABW_W];
        fld.prec = ref_q[PREC_AT];
        fld.aval = div_q[AVAL_LO +: AVAL_W];
        fld.bval = div_q[BVAL_LO +: BVAL_W];
        fld.mux  = func_q[MUX_LO +: MUX_W];
    end

endmodule

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader
    import cwl_pkg::*;
(
    input  logic                sclk,
    input  logic                sdata,
    input  logic                le,
    input  logic                rst,
    output logic [PAY_W-1:0]    lat_ref,
    output logic [PAY_W-1:0]    lat_div,
    output logic [PAY_W-1:0]    lat_func,
    output logic [PAY_W-1:0]    lat_init,
    output logic [RDIV_W-1:0]   ref_div,
    output logic [AVAL_W-1:0]   a_val,
    output logic [BVAL_W-1:0]   b_val,
    output logic                lock_prec,
    output logic [ABW_W-1:0]    abw_sel,
    output logic [MUX_W-1:0]    mux_sel
);

    logic [WORD_W-1:0]              sh_word;
    logic [N_LATCH-1:0][PAY_W-1:0]  lat;
    fields_t                        fld;

    cwl_shift #(.W(WORD_W)) u_shift (
        .sclk  (sclk),
        .rst   (rst),
        .sdata (sdata),
        .word  (sh_word)
    );

    cwl_bank u_bank (
        .le   (le),
        .rst  (rst),
        .word (sh_word),
        .lat  (lat)
    );

    cwl_decode u_dec (
        .ref_q  (lat[int'(SEL_REF)]),
        .div_q  (lat[int'(SEL_DIV)]),
        .func_q (lat[int'(SEL_FUNC)]),
        .fld    (fld)
    );

    assign lat_ref   = lat[int'(SEL_REF)];
    assign lat_div   = lat[int'(SEL_DIV)];
    assign lat_func  = lat[int'(SEL_FUNC)];
    assign lat_init  = lat[int'(SEL_INIT)];
    assign ref_div   = fld.rdiv;
    assign a_val     = fld.aval;
    assign b_val     = fld.bval;
    assign lock_prec = fld.prec;
    assign abw_sel   = fld.abw;
    assign mux_sel   = fld.mux;

endmodule

// File: rtl/cwl_checker.sv
module cwl_checker
    import cwl_pkg::*;
(
    input logic              sclk,
    input logic              le,
    input logic              rst,
    input logic              sdata,
    input logic [WORD_W-1:0] word,
    input logic [PAY_W-1:0]  lat_ref,
    input logic [PAY_W-1:0]  lat_div,
    input logic [PAY_W-1:0]  lat_func,
    input logic [PAY_W-1:0]  lat_init
);

    logic [CTRL_W-1:0] code;
    logic [PAY_W-1:0]  pay;
    assign code = word[CTRL_W-1:0];
    assign pay  = word[PAY_HI:PAY_LO];

    // R2: newest bit enters at the low end of the word
    p_shift_in_r2: assert property (@(posedge sclk) disable iff (rst)
        1'b1 |=> word[0] == $past(sdata));

    // R1: reset holds every latch at zero
    p_reset_clear_r1: assert property (@(posedge sclk)
        rst |-> (lat_ref == '0 && lat_div == '0 && lat_func == '0 && lat_init == '0));

    // R3: reference latch captures the word
    p_ref_load_r3: assert property (@(posedge le) disable iff (rst)
        code == 2'b00 |=> lat_ref == $past(pay));

    // R4: divider latch captures the word
    p_div_load_r4: assert property (@(posedge le) disable iff (rst)
        code == 2'b01 |=> lat_div == $past(pay));

    // R6: init write fills both init and function latches
    p_init_mirror_r6: assert property (@(posedge le) disable iff (rst)
        code == 2'b11 |=> (lat_init == $past(pay) && lat_func == $past(pay)));

    // R7: a reference write leaves the other latches alone
    p_keep_unsel_r7: assert property (@(posedge le) disable iff (rst)
        code == 2'b00 |=> ($stable(lat_div) && $stable(lat_func) && $stable(lat_init)));

endmodule

bind ctrl_word_loader cwl_checker u_chk (
    .sclk     (sclk),
    .le       (le),
    .rst      (rst),
    .sdata    (sdata),
    .word     (sh_word),
    .lat_ref  (lat_ref),
    .lat_div  (lat_div),
    .lat_func (lat_func),
    .lat_init (lat_init)
);

// File: tb/ctrl_word_loader_tb.sv
module ctrl_word_loader_tb;

    logic clk = 1'b0;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic le = 1'b0;
    logic rst = 1'b0;

    logic [21:0] lat_ref, lat_div, lat_func, lat_init;
    logic [13:0] ref_div;
    logic [5:0]  a_val;
    logic [12:0] b_val;
    logic        lock_prec;
    logic [1:0]  abw_sel;
    logic [2:0]  mux_sel;

    int n_run = 0;
    int n_fail = 0;

    // expected latch contents, as 22-bit payloads (word bits 23:2)
    logic [21:0] m_ref = '0, m_div = '0, m_func = '0, m_init = '0;

    always #5 clk = ~clk;

    ctrl_word_loader u_dut (
        .sclk(sclk), .sdata(sdata), .le(le), .rst(rst),
        .lat_ref(lat_ref), .lat_div(lat_div), .lat_func(lat_func), .lat_init(lat_init),
        .ref_div(ref_div), .a_val(a_val), .b_val(b_val), .lock_prec(lock_prec),
        .abw_sel(abw_sel), .mux_sel(mux_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // field of a word, given its bit position in the 24-bit word
    function automatic logic [31:0] fld(input logic [21:0] p, input int lo, input int w);
        logic [23:0] full;
        full = {p, 2'b00};
        return (32'(full) >> lo) & ((32'd1 << w) - 1);
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); sdata = b; sclk = 1'b0;
        @(negedge clk); sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic strobe(input logic [23:0] w);
        @(negedge clk); le = 1'b1;
        @(negedge clk); le = 1'b0;
        case (w[1:0])
            2'b00: m_ref = w[23:2];
            2'b01: m_div = w[23:2];
            2'b10: m_func = w[23:2];
            default: begin m_init = w[23:2]; m_func = w[23:2]; end
        endcase
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 ref latch"},  32'(lat_ref),  32'(m_ref));
        chk({tag, " R4 div latch"},  32'(lat_div),  32'(m_div));
        chk({tag, " R5 func latch"}, 32'(lat_func), 32'(m_func));
        chk({tag, " R6 init latch"}, 32'(lat_init), 32'(m_init));
        chk({tag, " R8 rdiv"},  32'(ref_div),   fld(m_ref, 2, 14));
        chk({tag, " R8 abw"},   32'(abw_sel),   fld(m_ref, 16, 2));
        chk({tag, " R8 prec"},  32'(lock_prec), fld(m_ref, 20, 1));
        chk({tag, " R9 aval"},  32'(a_val),     fld(m_div, 2, 6));
        chk({tag, " R9 bval"},  32'(b_val),     fld(m_div, 8, 13));
        chk({tag, " R10 mux"},  32'(mux_sel),   fld(m_func, 4, 3));
    endtask

    task automatic load(input logic [23:0] w, input string tag);
        shift_word(w);
        strobe(w);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] w;
        #1 rst = 1'b1;
        repeat (3) send_bit(1'b1);
        @(negedge clk); le = 1'b1;
        @(negedge clk); le = 1'b0;
        check_all("R1 reset");
        @(negedge clk); rst = 1'b0;
        @(negedge clk);

        // R9 / R4: sweep every A value, spread B values
        for (int a = 0; a < 64; a++) begin
            logic [12:0] b;
            b = 13'((a * 97 + 5) % 8192);
            w = {3'(a), b, 6'(a), 2'b01};
            load(w, "R4 R7 div sweep");
        end

        // R8 / R3: reference ratio, antibacklash and precision spread
        for (int k = 0; k < 32; k++) begin
            logic [13:0] r;
            r = 14'((k * 517 + 3) % 16384);
            w = {3'(k + 1), 1'(k), 2'(k >> 1), 2'(k), r, 2'b00};
            load(w, "R3 R8 ref sweep");
        end

        // R10 / R5: every multiplexer select
        for (int m = 0; m < 8; m++) begin
            w = {17'(m * 3001), 3'(m), 2'(m), 2'b10};
            load(w, "R5 R10 func sweep");
        end

        // R6: initialization writes mirror into the function latch
        for (int k = 0; k < 6; k++) begin
            w = {22'(k * 190027 + 11), 2'b11};
            load(w, "R6 init");
        end

        // R5 after init: function latch alone, init keeps its value (R7)
        load({22'h2AAAAA, 2'b10}, "R7 func after init");

        // R2: leading extra bits are pushed out
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 5 + k; j++) send_bit(1'(j ^ k));
            w = {22'(k * 31337 + 77), 2'(k)};
            load(w, "R2 overlong stream");
        end

        // R11: shifting without a strobe changes nothing
        shift_word({22'h3FFFFF, 2'b11});
        shift_word({22'h155555, 2'b01});
        check_all("R11 no strobe");

        // R1: asynchronous reset in mid-run
        @(negedge clk); rst = 1'b1;
        #1;
        m_ref = '0; m_div = '0; m_func = '0; m_init = '0;
        check_all("R1 async reset");
        @(negedge clk); rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule